// File: doc/BRIEF.md
# Chained Descriptor Copy Engine

This block moves blocks of data from one region of memory to another without processor involvement. Software first builds a chain of transfer descriptors in memory. Each descriptor takes four consecutive words: a source address, a destination address, a length in bytes, and the address of the next descriptor in the chain. Software then writes the address of the first descriptor into the head register. The engine reads the four descriptor words, copies that block one bus word at a time, and follows the link to the next descriptor. A link of zero ends the chain. The engine then sets a sticky done flag, which also drives the interrupt line.

The engine uses a single memory port for both descriptor reads and data moves. The port has a request channel and a read-response channel, and both use valid/ready handshakes. A request stays valid with its address, write flag and write data unchanged until the memory accepts it. Writes produce no response. After a read, the engine issues nothing more until the memory has delivered the read data and the engine has taken it. Only one access is ever outstanding. The memory may hold off the request by keeping ready low, and it may delay the response for any number of cycles.

The register port is a plain write strobe with a combinational read. Address 0 holds the head pointer, and writing it starts a chain. Address 1 is the status word: bit 0 is busy, bit 1 is done and bit 2 is error. Writing 1 to done or error clears that bit.

Top module: `chain_dma`

## Requirements
- R1: After reset, busy, done and error read as 0, irq is 0 and mem_req_valid is 0.
- R2: A write to register 0 while idle starts a chain at the written address. For every descriptor at address D, the engine first reads D (source), D+4 (destination), D+8 (byte length) and D+12 (next link), in that order, before it makes any data access for that descriptor.
- R3: Descriptors are serviced strictly one after another in link order. A descriptor's four-word fetch starts only after every data access of the previous descriptor. A next link of 0 ends the chain.
- R4: A descriptor with byte length L moves ceil(L/4) words. For beat k, counting up from 0, the engine reads source+4k and then writes that word to destination+4k.
- R5: A descriptor with length 0 produces no data access, and the engine goes straight on to its next link.
- R6: When the chain ends, busy drops, done (status bit 1) becomes 1 and stays 1, and irq follows done. Starting with a head address of 0 sets done without any memory access.
- R7: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 to a bit leaves it unchanged.
- R8: A write to register 0 while busy is ignored, so the running chain is unaffected, and it sets error (status bit 2).
- R9: A request stays valid and stable until it is accepted. Only one memory access is outstanding at a time. A read response is consumed only in a cycle where both mem_rsp_valid and mem_rsp_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 head, 1 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt, high while done is set |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine takes read data |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench uses the default 32-bit address and data widths, so there are 4 bytes per word. That makes byte lengths that are not a multiple of four, and the rounding up to whole words they cause, easy to reach with short blocks. It also keeps a 512-word memory model large enough for chains of up to four descriptors scattered over their own region. The memory model varies request acceptance and response delay at random. That exercises request stalls and response waits in both the descriptor fetch and the copy, while the bench compares every accepted request against a request order it derives from the chain.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_FREQ, W_FRSP, W_LAUNCH, W_WAIT, W_NEXT
  } walk_state_t;

  typedef enum logic [1:0] {
    M_IDLE, M_RREQ, M_RRSP, M_WREQ
  } move_state_t;

  localparam int DESC_WORDS = 4;
  localparam int F_SRC  = 0;
  localparam int F_DST  = 1;
  localparam int F_LEN  = 2;
  localparam int F_NEXT = 3;

  localparam int REG_HEAD   = 0;
  localparam int REG_STATUS = 1;
  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
endpackage

// File: rtl/chain_dma_csr.sv
module chain_dma_csr
  import chain_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           busy_i,
  input  logic           finish_i,
  output logic           start_o,
  output logic [AW-1:0]  head_o,
  output logic           irq_o
);
  logic [AW-1:0] head_q;
  logic done_q, err_q;
  logic wr_head, wr_stat;

  assign wr_head = reg_wr && (reg_addr == RAW'(REG_HEAD));
  assign wr_stat = reg_wr && (reg_addr == RAW'(REG_STATUS));
  assign start_o = wr_head && !busy_i;
  assign head_o  = start_o ? reg_wdata[AW-1:0] : head_q;
  assign irq_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (start_o) head_q <= reg_wdata[AW-1:0];
      if (finish_i) done_q <= 1'b1;
      else if (wr_stat && reg_wdata[ST_DONE]) done_q <= 1'b0;
      if (wr_head && busy_i) err_q <= 1'b1;
      else if (wr_stat && reg_wdata[ST_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(REG_HEAD)) begin
      reg_rdata[AW-1:0] = head_q;
    end else if (reg_addr == RAW'(REG_STATUS)) begin
      reg_rdata[ST_BUSY] = busy_i;
      reg_rdata[ST_DONE] = done_q;
      reg_rdata[ST_ERR]  = err_q;
    end
  end

  // R6: end of chain always leaves done set
  a_r6_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |=> done_q);
  // R8: a head write during a chain must leave the stored head untouched
  a_r8_busy_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_head && busy_i) |=> $stable(head_q) && err_q);
endmodule

// File: rtl/chain_dma_mover.sv
module chain_dma_mover
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] len_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  output logic          rsp_ready_o,
  input  logic [DW-1:0] rsp_data_i,
  output logic          done_o
);
  localparam int WB = DW / 8;
  localparam int SH = $clog2(WB);

  move_state_t   st;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] cnt_q, data_q, beats;

  assign beats = (len_i >> SH) + DW'(|len_i[SH-1:0]);

  assign req_valid_o = (st == M_RREQ) || (st == M_WREQ);
  assign req_write_o = (st == M_WREQ);
  assign req_addr_o  = (st == M_WREQ) ? dst_q : src_q;
  assign req_wdata_o = data_q;
  assign rsp_ready_o = (st == M_RRSP);
  assign done_o      = (st == M_WREQ) && req_ready_i && (cnt_q == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      case (st)
        M_IDLE: if (start_i) begin
          src_q <= src_i;
          dst_q <= dst_i;
          cnt_q <= beats;
          st    <= M_RREQ;
        end
        M_RREQ: if (req_ready_i) st <= M_RRSP;
        M_RRSP: if (rsp_valid_i) begin
          data_q <= rsp_data_i;
          st     <= M_WREQ;
        end
        M_WREQ: if (req_ready_i) begin
          cnt_q <= cnt_q - DW'(1);
          if (cnt_q == DW'(1)) begin
            st <= M_IDLE;
          end else begin
            src_q <= src_q + AW'(WB);
            dst_q <= dst_q + AW'(WB);
            st    <= M_RREQ;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R5: the walker never hands over an empty block
  a_r5_no_empty_block: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (len_i != '0) && (st == M_IDLE));
  // R4: destination advances in step with the source on every beat
  a_r4_addr_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_WREQ && req_ready_i && cnt_q != DW'(1)) |=>
      (src_q - $past(src_q) == AW'(WB)) && (dst_q - $past(dst_q) == AW'(WB)));
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] head_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  output logic          rsp_ready_o,
  input  logic [DW-1:0] rsp_data_i,
  output logic          mv_start_o,
  output logic [AW-1:0] mv_src_o,
  output logic [AW-1:0] mv_dst_o,
  output logic [DW-1:0] mv_len_o,
  input  logic          mv_done_i,
  output logic          busy_o,
  output logic          finish_o
);
  localparam int WB = DW / 8;
  localparam int SH = $clog2(WB);
  localparam int IW = $clog2(DESC_WORDS);

  walk_state_t   st;
  logic [AW-1:0] cur_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] fld [DESC_WORDS];
  logic          link_zero;

  assign link_zero   = (fld[F_NEXT][AW-1:0] == '0);
  assign req_valid_o = (st == W_FREQ);
  assign req_addr_o  = cur_q + (AW'(idx_q) << SH);
  assign rsp_ready_o = (st == W_FRSP);
  assign mv_start_o  = (st == W_LAUNCH) && (fld[F_LEN] != '0);
  assign mv_src_o    = fld[F_SRC][AW-1:0];
  assign mv_dst_o    = fld[F_DST][AW-1:0];
  assign mv_len_o    = fld[F_LEN];
  assign busy_o      = (st != W_IDLE);
  assign finish_o    = ((st == W_IDLE) && start_i && (head_i == '0)) ||
                       ((st == W_NEXT) && link_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= W_IDLE;
      cur_q <= '0;
      idx_q <= '0;
      for (int i = 0; i < DESC_WORDS; i++) fld[i] <= '0;
    end else begin
      case (st)
        W_IDLE: if (start_i && head_i != '0) begin
          cur_q <= head_i;
          idx_q <= '0;
          st    <= W_FREQ;
        end
        W_FREQ: if (req_ready_i) st <= W_FRSP;
        W_FRSP: if (rsp_valid_i) begin
          fld[idx_q] <= rsp_data_i;
          if (idx_q == IW'(DESC_WORDS - 1)) begin
            st <= W_LAUNCH;
          end else begin
            idx_q <= idx_q + IW'(1);
            st    <= W_FREQ;
          end
        end
        W_LAUNCH: st <= (fld[F_LEN] == '0) ? W_NEXT : W_WAIT;
        W_WAIT:   if (mv_done_i) st <= W_NEXT;
        W_NEXT: begin
          if (link_zero) begin
            st <= W_IDLE;
          end else begin
            cur_q <= fld[F_NEXT][AW-1:0];
            idx_q <= '0;
            st    <= W_FREQ;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R3: the next fetch never begins while a block is still moving
  a_r3_fetch_after_move: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_WAIT && !mv_done_i) |=> (st == W_WAIT) && !req_valid_o);
  // R6: finishing always returns the engine to idle
  a_r6_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !busy_o);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  input  logic           mem_rsp_valid,
  output logic           mem_rsp_ready,
  input  logic [DW-1:0]  mem_rsp_data
);
  logic          start, busy, finish;
  logic [AW-1:0] head;
  logic          w_valid, w_rsp_ready;
  logic [AW-1:0] w_addr;
  logic          m_valid, m_write, m_rsp_ready, m_start, m_done;
  logic [AW-1:0] m_addr, m_src, m_dst;
  logic [DW-1:0] m_wdata, m_len;

  chain_dma_csr #(.AW(AW), .DW(DW), .RAW(RAW)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
    .finish_i(finish), .start_o(start), .head_o(head), .irq_o(irq)
  );

  chain_dma_walker #(.AW(AW), .DW(DW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start), .head_i(head),
    .req_valid_o(w_valid), .req_ready_i(mem_req_ready), .req_addr_o(w_addr),
    .rsp_valid_i(mem_rsp_valid), .rsp_ready_o(w_rsp_ready),
    .rsp_data_i(mem_rsp_data), .mv_start_o(m_start), .mv_src_o(m_src),
    .mv_dst_o(m_dst), .mv_len_o(m_len), .mv_done_i(m_done),
    .busy_o(busy), .finish_o(finish)
  );

  chain_dma_mover #(.AW(AW), .DW(DW)) u_move (
    .clk(clk), .rst_n(rst_n), .start_i(m_start), .src_i(m_src),
    .dst_i(m_dst), .len_i(m_len), .req_valid_o(m_valid),
    .req_ready_i(mem_req_ready), .req_write_o(m_write),
    .req_addr_o(m_addr), .req_wdata_o(m_wdata),
    .rsp_valid_i(mem_rsp_valid), .rsp_ready_o(m_rsp_ready),
    .rsp_data_i(mem_rsp_data), .done_o(m_done)
  );

  assign mem_req_valid = w_valid | m_valid;
  assign mem_req_write = m_valid & m_write;
  assign mem_req_addr  = m_valid ? m_addr : w_addr;
  assign mem_req_wdata = m_wdata;
  assign mem_rsp_ready = w_rsp_ready | m_rsp_ready;

  // R9: a stalled request keeps its content
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid &&
      $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));
  // R9: only one source drives the port at once
  a_r9_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({w_valid, m_valid}));
  // R9: no new request while a read is outstanding
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
  // R1: the port stays quiet when no chain runs
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
endmodule

// File: tb/test_chain_dma.sv
module test_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  chain_dma i_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int errors = 0;
  int checks = 0;
  int nreq = 0;
  logic [31:0] mem [512];
  logic [31:0] exp_mem [512];
  logic [31:0] q_addr [$];
  logic        q_we [$];
  logic [31:0] q_data [$];
  logic        rsp_pend = 0, rsp_taken = 0;
  logic [31:0] rsp_word;
  int          rsp_wait = 0;
  bit          model_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // memory model: decisions at the falling edge take effect at the next rise
  always @(negedge clk) begin
    if (model_on) begin
      if (rsp_taken) begin mem_rsp_valid = 1'b0; rsp_taken = 0; end
      if (rsp_pend && !mem_rsp_valid) begin
        if (rsp_wait == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = rsp_word; rsp_pend = 0;
        end else rsp_wait--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        nreq++;
        if (q_addr.size() == 0) begin
          chk(0, "R3 unexpected request", mem_req_addr, 32'hffffffff);
        end else begin
          logic [31:0] ea, ed; logic ew;
          ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_data.pop_front();
          chk(mem_req_addr == ea && mem_req_write == ew, "R2 R4 request order",
              {mem_req_addr[30:0], mem_req_write}, {ea[30:0], ew});
          if (ew) chk(mem_req_wdata == ed, "R4 write data", mem_req_wdata, ed);
        end
        if (mem_req_write) mem[mem_req_addr[10:2]] = mem_req_wdata;
        else begin
          rsp_pend = 1; rsp_word = mem[mem_req_addr[10:2]]; rsp_wait = $urandom % 3;
        end
      end
      if (mem_rsp_valid && mem_rsp_ready) rsp_taken = 1;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int a, input int s, input int d, input int l, input int n);
    mem[a/4] = s; mem[a/4+1] = d; mem[a/4+2] = l; mem[a/4+3] = n;
  endtask

  task automatic build_expect(input logic [31:0] head);
    logic [31:0] d, s, t, l, nx, w;
    int guard;
    for (int i = 0; i < 512; i++) exp_mem[i] = mem[i];
    d = head; guard = 0;
    while (d != 0 && guard < 16) begin
      for (int i = 0; i < 4; i++) begin
        q_addr.push_back(d + 4*i); q_we.push_back(0); q_data.push_back(0);
      end
      s = exp_mem[d[10:2]]; t = exp_mem[d[10:2]+1];
      l = exp_mem[d[10:2]+2]; nx = exp_mem[d[10:2]+3];
      for (int b = 0; b < (l + 3) / 4; b++) begin
        w = exp_mem[s[10:2] + b];
        q_addr.push_back(s + 4*b); q_we.push_back(0); q_data.push_back(0);
        q_addr.push_back(t + 4*b); q_we.push_back(1); q_data.push_back(w);
        exp_mem[t[10:2] + b] = w;
      end
      d = nx; guard++;
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq, {tag, " R6 irq after chain"}, {31'd0, irq}, 32'd1);
  endtask

  task automatic finish_chain(input string tag, input logic [31:0] exp_stat);
    logic [31:0] st;
    int bad = 0;
    repeat (3) @(negedge clk);
    chk(q_addr.size() == 0, {tag, " R3 all requests seen"}, q_addr.size(), 0);
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, {tag, " R4 memory image"}, bad, 0);
    reg_read(2'd1, st);
    chk(st == exp_stat, {tag, " R6 status at end"}, st, exp_stat);
    reg_write(2'd1, 32'h6);
    reg_read(2'd1, st);
    chk(st == 0 && !irq, {tag, " R7 status cleared"}, st, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] st;
    int seedv, n0;
    seedv = $urandom(32'd4711);
    for (int i = 0; i < 512; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(2'd1, st);
    chk(st == 0, "R1 status after reset", st, 0);
    chk(irq == 0 && mem_req_valid == 0, "R1 irq and request idle",
        {30'd0, irq, mem_req_valid}, 0);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);

    // directed chain: 16 bytes, empty block (R5), 5 bytes rounds up (R4)
    put_desc(32'h000, 32'h100, 32'h400, 16, 32'h020);
    put_desc(32'h020, 32'h140, 32'h480, 0,  32'h040);
    put_desc(32'h040, 32'h180, 32'h500, 5,  0);
    build_expect(32'h000 + 32'h0);
    // head 0x000 is the null link, so place this chain at 0x010 instead
    q_addr.delete(); q_we.delete(); q_data.delete();
    put_desc(32'h010, 32'h100, 32'h400, 16, 32'h020);
    build_expect(32'h010);
    reg_write(2'd0, 32'h010);
    reg_read(2'd1, st);
    chk(st[0] == 1, "R2 busy after start", st, 1);
    wait_done("directed");
    finish_chain("directed R5", 32'h2);

    // R6 head of zero: done with no memory access
    n0 = nreq;
    reg_write(2'd0, 32'h0);
    @(negedge clk);
    reg_read(2'd1, st);
    chk(st == 32'h2 && irq, "R6 null head sets done", st, 32'h2);
    chk(nreq == n0, "R6 null head no access", nreq - n0, 0);
    // R7 writing 0 leaves done, writing 1 clears it
    reg_write(2'd1, 32'h0);
    reg_read(2'd1, st);
    chk(st == 32'h2, "R7 write zero keeps done", st, 32'h2);
    reg_write(2'd1, 32'h2);
    reg_read(2'd1, st);
    chk(st == 0, "R7 write one clears done", st, 0);

    // R8 second start while busy is ignored and flags error
    put_desc(32'h060, 32'h200, 32'h600, 24, 0);
    build_expect(32'h060);
    reg_write(2'd0, 32'h060);
    reg_write(2'd0, 32'h010);
    reg_read(2'd1, st);
    chk(st[2] == 1, "R8 error after busy start", st, 32'h5);
    reg_read(2'd0, st);
    chk(st == 32'h060, "R8 head unchanged", st, 32'h060);
    wait_done("busy-start");
    reg_read(2'd1, st);
    chk(st == 32'h6, "R8 done and error", st, 32'h6);
    reg_write(2'd1, 32'h4);
    reg_read(2'd1, st);
    chk(st == 32'h2, "R7 error cleared alone", st, 32'h2);
    finish_chain("busy-start R8", 32'h2);

    // random chains, scattered descriptors, random lengths
    for (int it = 0; it < 8; it++) begin
      int nd;
      int da [4];
      nd = 1 + ($urandom % 4);
      for (int k = 0; k < nd; k++) da[k] = 16 * (((3 * k + it) % 15) + 1);
      for (int k = 0; k < nd; k++)
        put_desc(da[k], 32'h100 + 4 * ($urandom % 128), 32'h400 + 4 * ($urandom % 200),
                 $urandom % 41, (k == nd - 1) ? 0 : da[k + 1]);
      build_expect(da[0]);
      reg_write(2'd0, da[0]);
      wait_done("random R3");
      finish_chain("random R3", 32'h2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule